// File: doc/BRIEF.md
# Three-Weight Accumulator Pattern Source

This block is a built-in self-test stimulus source. It drives the primary inputs of a circuit under test with weighted patterns, one pattern per clock. Each input bit gets a weight of 0, 1 or one half in every test session. Bits weighted 0 or 1 are held at that constant for the whole session. Bits weighted one half take pseudo-random values.

The random values come from an ordinary ripple accumulator built from full-adder cells. Register A holds the running sum and register B holds the addend. A per-bit pair of force lines sets or clears the flip-flops of both registers, with opposite polarity in A and in B. A forced bit therefore shows A = weight and B = not weight to its adder cell. Its carry passes through unchanged, and the adder itself is never modified.

A session controller walks K sessions, each N patterns long. For every session it reads a vector of 2-bit weight codes from an external table port, and it raises a done flag at the end.

Top module: `wtpg_top`

## Requirements
- R1: While reset is held, and after reset until the first start, `pattern_valid_o` and `done_o` are 0.
- R2: A bit whose weight code is 2'b01 reads 0 on every valid pattern of that session.
- R3: A bit whose weight code is 2'b10 reads 1 on every valid pattern of that session.
- R4: Weight code 2'b11 is reserved and behaves exactly like the free code 2'b00.
- R5: Free bits follow an exact sequence:
  - On start, A and B clear and a 16-bit LFSR loads seed 16'hACE1.
  - After each valid pattern that is not the last, A becomes (A_eff + B_eff) mod 2^n, where A_eff and B_eff are the register values with the force lines applied.
  - After the same patterns, B[i] loads LFSR bit (i mod 16), and the LFSR shifts left with new bit s[15]^s[13]^s[12]^s[10].
- R6: After start, `pattern_valid_o` is high for exactly N consecutive clocks per session. Sessions run back to back in order 0..K-1, and `tbl_addr_o` equals the session index during its patterns.
- R7: From the clock after the last pattern of session K-1, `done_o` is 1 and `pattern_valid_o` is 0. `pattern_o` then holds the last pattern until the next start.
- R8: Start restarts from session 0 with A, B and the LFSR reinitialised. This holds when start is raised mid-run and when it is raised after done.
- R9: A forced bit presents A = w and B = not w to its adder cell. The carry into it therefore reaches the next bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins, or restarts, the session sequence |
| tbl_addr_o | output | SESS_W | Current session index, used as the weight-table address |
| tbl_data_i | input | 2*N_BITS | Weight codes for the addressed session, bit i in [2i+1:2i], read combinationally |
| pattern_o | output | N_BITS | Pattern applied to the circuit under test |
| pattern_valid_o | output | 1 | High on each clock that carries a test pattern |
| done_o | output | 1 | High once all sessions have completed |

## Verification
The bench builds the block with N_BITS = 20, K = 4 and N = 6. Twenty bits is more than the LFSR width, so the wrap of LFSR taps across high bits is exercised.

Four sessions reach all four weight codes:
- one all free,
- one alternating forced 0 and 1,
- one mixed with free bits sitting above forced bits, so carries must cross them,
- one made only of the reserved code.

Six patterns per session leave room for carries to build up in the free bits. The session counts are small enough to run the sequence three times: after reset, after a mid-run restart, and after a restart from done.

// File: rtl/wtpg_pkg.sv
// Package: shared types and constants of the weighted pattern source.
// Assumes: weight codes are 2 bits per input bit.
package wtpg_pkg;

    // Weight code of one input bit; RSVD behaves as FREE.
    typedef enum logic [1:0] {
        W_FREE = 2'b00,
        W_ZERO = 2'b01,
        W_ONE  = 2'b10,
        W_RSVD = 2'b11
    } wcode_e;

    // Controller state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_DONE = 2'b10
    } gen_state_e;

    localparam int LFSR_W = 16;

endpackage

// File: rtl/wtpg_weight_map.sv
// Module: wtpg_weight_map
// Turns the per-bit weight codes into force-high and force-low lines.
// Assumes: code of bit i sits at codes_i[2i+1:2i]; reserved code leaves the bit free.
module wtpg_weight_map
    import wtpg_pkg::*;
#(
    parameter int N_BITS = 16
) (
    input  logic [2*N_BITS-1:0] codes_i,
    output logic [N_BITS-1:0]   force_hi_o,
    output logic [N_BITS-1:0]   force_lo_o
);

    for (genvar i = 0; i < N_BITS; i++) begin : g_bit
        wcode_e code;
        assign code = wcode_e'(codes_i[2*i+1 -: 2]);

        // Decode one bit's weight code into its force lines.
        always_comb begin
            force_hi_o[i] = 1'b0;
            force_lo_o[i] = 1'b0;
            case (code)
                W_ONE:   force_hi_o[i] = 1'b1;
                W_ZERO:  force_lo_o[i] = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wtpg_lfsr.sv
// Module: wtpg_lfsr
// 16-bit maximal-length Fibonacci LFSR, taps 16,14,13,11, shifting left.
// Assumes: SEED is nonzero; restart has priority over step.
module wtpg_lfsr
    import wtpg_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              step_i,
    output logic [LFSR_W-1:0] state_o
);

    logic [LFSR_W-1:0] lfsr_q;
    logic              fb;

    // Feedback bit from the polynomial taps.
    assign fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

    // Reseed on reset or restart, otherwise shift when stepped.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            lfsr_q <= SEED;
        end else if (step_i) begin
            lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
        end
    end

    assign state_o = lfsr_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0) else $error("lfsr reached zero"); // R5

endmodule

// File: rtl/wtpg_accum.sv
// Module: wtpg_accum
// Ripple accumulator of full-adder cells with sum register A and addend register B.
// Each bit's force lines act at once on both flops with opposite polarity:
// force_hi gives A=1/B=0 and force_lo gives A=0/B=1, so the carry passes through.
// Assumes: force_hi and force_lo are never both high on one bit.
module wtpg_accum #(
    parameter int N_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              advance_i,
    input  logic [N_BITS-1:0] force_hi_i,
    input  logic [N_BITS-1:0] force_lo_i,
    input  logic [N_BITS-1:0] b_load_i,
    output logic [N_BITS-1:0] a_o
);

    logic [N_BITS-1:0] a_q, b_q;
    logic [N_BITS-1:0] a_eff, b_eff, sum;
    logic [N_BITS:0]   carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < N_BITS; i++) begin : g_cell
        // Forced flop outputs; the B set line is the A reset line and vice versa.
        assign a_eff[i] = force_hi_i[i] | (~force_lo_i[i] & a_q[i]);
        assign b_eff[i] = force_lo_i[i] | (~force_hi_i[i] & b_q[i]);

        // Unmodified full-adder cell.
        assign sum[i]     = a_eff[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1] = (a_eff[i] & b_eff[i]) | (carry[i] & (a_eff[i] ^ b_eff[i]));

        AST_CARRY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (force_hi_i[i] || force_lo_i[i]) |-> (carry[i+1] == carry[i]))
            else $error("forced bit altered carry"); // R9
    end

    // Accumulate and reload the addend; clear on reset or start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            a_q <= '0;
            b_q <= '0;
        end else if (advance_i) begin
            a_q <= sum;
            b_q <= b_load_i;
        end
    end

    assign a_o = a_eff;

    AST_FORCE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (force_hi_i & force_lo_i) == '0) else $error("both force lines high"); // R2

endmodule

// File: rtl/wtpg_session_ctrl.sv
// Module: wtpg_session_ctrl
// Steps through K sessions of N patterns each and flags completion.
// Assumes: K >= 1 and N >= 1; start has priority in every state.
module wtpg_session_ctrl
    import wtpg_pkg::*;
#(
    parameter int K      = 4,
    parameter int N_PATS = 8,
    parameter int SESS_W = (K > 1) ? $clog2(K) : 1,
    parameter int PAT_W  = (N_PATS > 1) ? $clog2(N_PATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [SESS_W-1:0] sess_o,
    output logic              valid_o,
    output logic              advance_o,
    output logic              done_o
);

    localparam logic [SESS_W-1:0] SESS_LAST = SESS_W'(K - 1);
    localparam logic [PAT_W-1:0]  PAT_LAST  = PAT_W'(N_PATS - 1);

    gen_state_e        state_q;
    logic [SESS_W-1:0] sess_q;
    logic [PAT_W-1:0]  pat_q;
    logic              last_pat, last_all;

    assign last_pat = (pat_q == PAT_LAST);
    assign last_all = last_pat && (sess_q == SESS_LAST);

    // State and counter update: start clears, sessions advance after N patterns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sess_q  <= '0;
            pat_q   <= '0;
        end else if (start_i) begin
            state_q <= ST_RUN;
            sess_q  <= '0;
            pat_q   <= '0;
        end else if (state_q == ST_RUN) begin
            if (last_all) begin
                state_q <= ST_DONE;
            end else if (last_pat) begin
                pat_q  <= '0;
                sess_q <= sess_q + 1'b1;
            end else begin
                pat_q <= pat_q + 1'b1;
            end
        end
    end

    assign sess_o    = sess_q;
    assign valid_o   = (state_q == ST_RUN);
    assign done_o    = (state_q == ST_DONE);
    // The last pattern does not advance, so the output holds once done.
    assign advance_o = valid_o && !last_all && !start_i;

    AST_VALID_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && done_o)) else $error("valid during done"); // R7
    AST_SESS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sess_q <= SESS_LAST) else $error("session out of range"); // R6
    AST_PAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pat_q <= PAT_LAST) else $error("pattern count out of range"); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && last_all && !start_i) |=> done_o) else $error("done missing"); // R7
    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && sess_q == '0)) else $error("start ignored"); // R8

endmodule

// File: rtl/wtpg_top.sv
// Module: wtpg_top
// Accumulator-based three-weight test pattern source.
// Assumes: tbl_data_i is a combinational read of the entry addressed by tbl_addr_o,
// stable while its address is stable.
module wtpg_top
    import wtpg_pkg::*;
#(
    parameter int                N_BITS = 16,
    parameter int                K      = 4,
    parameter int                N_PATS = 8,
    parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
    parameter int                SESS_W = (K > 1) ? $clog2(K) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    output logic [SESS_W-1:0]   tbl_addr_o,
    input  logic [2*N_BITS-1:0] tbl_data_i,
    output logic [N_BITS-1:0]   pattern_o,
    output logic                pattern_valid_o,
    output logic                done_o
);

    logic [N_BITS-1:0] force_hi, force_lo, b_load;
    logic [LFSR_W-1:0] lfsr_state;
    logic              advance;

    wtpg_session_ctrl #(.K(K), .N_PATS(N_PATS), .SESS_W(SESS_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .sess_o    (tbl_addr_o),
        .valid_o   (pattern_valid_o),
        .advance_o (advance),
        .done_o    (done_o)
    );

    wtpg_weight_map #(.N_BITS(N_BITS)) map_i (
        .codes_i    (tbl_data_i),
        .force_hi_o (force_hi),
        .force_lo_o (force_lo)
    );

    wtpg_lfsr #(.SEED(SEED)) lfsr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (start_i),
        .step_i    (advance),
        .state_o   (lfsr_state)
    );

    // Each addend bit takes LFSR tap (i mod 16).
    for (genvar i = 0; i < N_BITS; i++) begin : g_tap
        assign b_load[i] = lfsr_state[i % LFSR_W];
    end

    wtpg_accum #(.N_BITS(N_BITS)) acc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .advance_i  (advance),
        .force_hi_i (force_hi),
        .force_lo_i (force_lo),
        .b_load_i   (b_load),
        .a_o        (pattern_o)
    );

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(pattern_o)))
        else $error("output moved while done"); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pattern_valid_o && !done_o && !start_i) |=> !pattern_valid_o)
        else $error("valid without start"); // R1
    AST_FORCED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_valid_o |-> (((pattern_o & force_hi) == force_hi) && ((pattern_o & force_lo) == '0)))
        else $error("forced bit wrong"); // R3

endmodule

// File: tb/wtpg_top_tb.sv
module wtpg_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 20;
    localparam int KS = 4;
    localparam int NP = 6;
    localparam int SW = 2;

    // Weight table: one entry per session, code of bit i at [2i+1:2i]
    // (00 free, 01 zero, 10 one, 11 reserved=free).
    localparam logic [2*NB-1:0] WTAB [KS] = '{
        40'h00_0000_0000,   // all free
        40'h99_9999_9999,   // alternating 0 / 1
        40'hA5_0F00_6102,   // mixed, free bits above forced bits, some reserved
        40'hFF_FFFF_FFFF    // all reserved
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [SW-1:0] tbl_addr;
    logic [2*NB-1:0] tbl_data;
    logic [NB-1:0] pattern;
    logic          valid, done;

    int checks = 0;
    int errors = 0;

    logic [NB-1:0] mA, mB;
    logic [15:0]   mL;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign tbl_data = WTAB[tbl_addr];

    wtpg_top #(.N_BITS(NB), .K(KS), .N_PATS(NP), .SEED(16'hACE1), .SESS_W(SW)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start),
        .tbl_addr_o      (tbl_addr),
        .tbl_data_i      (tbl_data),
        .pattern_o       (pattern),
        .pattern_valid_o (valid),
        .done_o          (done)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected A_eff / B_eff from the requirement model for session s.
    function automatic logic [2*NB-1:0] model_eff(input int s);
        logic [NB-1:0] a, b;
        for (int i = 0; i < NB; i++) begin
            case (WTAB[s][2*i+1 -: 2])
                2'b01:   begin a[i] = 1'b0; b[i] = 1'b1; end
                2'b10:   begin a[i] = 1'b1; b[i] = 1'b0; end
                default: begin a[i] = mA[i]; b[i] = mB[i]; end
            endcase
        end
        return {a, b};
    endfunction

    function automatic logic [NB-1:0] mask_of(input int s, input logic [1:0] c);
        logic [NB-1:0] m;
        for (int i = 0; i < NB; i++) m[i] = (WTAB[s][2*i+1 -: 2] == c);
        return m;
    endfunction

    // Pulse start; walk all sessions, or stop early after stop_after patterns.
    task automatic run_seq(input int stop_after, input string tag);
        logic [2*NB-1:0] eff;
        logic [NB-1:0]   ea, eb, m0, m1, mf, last;
        int n;
        n = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        mA = '0; mB = '0; mL = 16'hACE1;
        for (int s = 0; s < KS; s++) begin
            for (int p = 0; p < NP; p++) begin
                if (stop_after >= 0 && n == stop_after) return;
                eff = model_eff(s);
                ea = eff[2*NB-1:NB];
                eb = eff[NB-1:0];
                m0 = mask_of(s, 2'b01);
                m1 = mask_of(s, 2'b10);
                mf = ~(m0 | m1);
                check(valid === 1'b1, {tag, " R6 valid"}, 64'(valid), 64'd1);
                check(tbl_addr === SW'(s), {tag, " R6 addr"}, 64'(tbl_addr), 64'(s));
                if (m0 != '0) check((pattern & m0) === '0, {tag, " R2 zero bits"}, 64'(pattern & m0), 64'd0);
                if (m1 != '0) check((pattern & m1) === m1, {tag, " R3 one bits"}, 64'(pattern & m1), 64'(m1));
                if (s == 3)
                    check((pattern & mf) === (ea & mf), {tag, " R4 reserved free bits"}, 64'(pattern), 64'(ea));
                else if (s == 2)
                    check((pattern & mf) === (ea & mf), {tag, " R5 R9 free bits across forced"}, 64'(pattern), 64'(ea));
                else
                    check((pattern & mf) === (ea & mf), {tag, " R5 free bits"}, 64'(pattern), 64'(ea));
                last = pattern;
                if (!(s == KS-1 && p == NP-1)) begin
                    mA = ea + eb;
                    for (int i = 0; i < NB; i++) mB[i] = mL[i % 16];
                    mL = {mL[14:0], mL[15] ^ mL[13] ^ mL[12] ^ mL[10]};
                end
                n++;
                @(negedge clk);
            end
        end
        for (int h = 0; h < 4; h++) begin
            check(done === 1'b1 && valid === 1'b0, {tag, " R7 done flags"}, {62'd0, done, valid}, 64'd2);
            check(pattern === last, {tag, " R7 hold"}, 64'(pattern), 64'(last));
            @(negedge clk);
        end
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(valid === 1'b0 && done === 1'b0, "R1 in reset", {62'd0, valid, done}, 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(valid === 1'b0 && done === 1'b0, "R1 idle after reset", {62'd0, valid, done}, 64'd0);
        run_seq(-1, "first");
        run_seq(8, "abort");
        run_seq(-1, "R8 restart midrun");
        run_seq(-1, "R8 restart after done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule